// File: doc/BRIEF.md
# Link Clock Frequency Change Monitor

This block watches an incoming link clock and tells the rest of the chip when its frequency has moved. A free-running counter in the link domain counts clock edges. The count crosses into a stable reference domain. At the end of each measurement window of fixed length, the block takes the edge count for that window and converts it to MHz. It compares the result with a stored baseline frequency. The comparison uses a programmable tolerance of whole MHz.

When the difference is larger than the tolerance, the block does three things. It sets a sticky change flag, which stays set until software writes a clear. It raises a one-cycle mute pulse that downstream audio logic can use to silence output. It also adopts the new measurement as the baseline. Software reaches the tolerance field and the flag through a small two-address register port.

Top module: `lnk_freq_mon`

## Requirements
- R1: After reset the change flag is 0, `muteMask` is low, and the tolerance field reads 4 (binary 0100).
- R2: Register address 0 holds the 4-bit tolerance in MHz in data bits [3:0], and it reads back what was written. A write to address 1 leaves the tolerance unchanged.
- R3: A measurement is the number of link-clock edges in a window of REF_MHZ×WIN_US reference cycles, divided by WIN_US. The first window after reset is discarded. The second window becomes the baseline and never raises the flag. The reference clock must run faster than the link clock.
- R4: When the absolute difference between a measurement and the baseline is strictly greater than the tolerance, the flag is set. A difference equal to or below the tolerance leaves the flag alone. With a tolerance of 0, any difference sets the flag.
- R5: Once set, the flag stays 1 until a write to address 1 with data bit 0 set. A write to address 1 with bit 0 clear has no effect. The flag reads at address 1, bit 0, with the upper bits 0, and it also drives `freqChanged`.
- R6: If a clear write and a new detection fall in the same cycle, the flag ends up 1.
- R7: The baseline is replaced only by a measurement that triggered a detection. Measurements within tolerance leave it unchanged, so slow drift builds up until it crosses the tolerance.
- R8: `muteMask` goes high for exactly one cycle, on the same edge at which the flag is set by a detection. This happens for every detection, even while the flag is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Stable reference clock (REF_MHZ) |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| linkClk | input | 1 | Link clock being monitored |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 tolerance, 1 status |
| regWrData | input | 4 | Register write data |
| regRdData | output | 4 | Register read data for `regAddr` |
| freqChanged | output | 1 | Sticky frequency-change flag |
| muteMask | output | 1 | One-cycle pulse on each detected change |

## Verification
The hardest case to reach is a clear write that lands in the exact cycle a detection is evaluated. The bench gets there by counting reference cycles from reset release. Window boundaries fall at fixed multiples of the window length, so the bench can step the link frequency just before a boundary. Two cycles after the window that measures the new rate closes, it asserts the clear in the evaluation cycle. The same alignment keeps each measured window on a single frequency. This lets expected outcomes be checked with a margin that covers the one-edge counting error.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  // Strobes from the control sequencer to the measurement datapath
  typedef struct packed {
    logic winEnd;    // capture the synchronized edge count this cycle
    logic loadBase;  // latch the current measurement as the baseline
  } lfmStrobe_t;

  typedef enum logic [1:0] {
    PH_PRIME = 2'd0,  // first window: count history not yet valid
    PH_BASE  = 2'd1,  // second window: establishes the baseline
    PH_RUN   = 2'd2   // compare every window
  } lfmPhase_t;

endpackage

// File: rtl/lfm_datapath.sv
module lfm_datapath
  import lfm_pkg::*;
#(
  parameter int MHZ_W  = 10,
  parameter int TOL_W  = 4,
  parameter int WIN_US = 1
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             linkClk,
  input  lfmStrobe_t       strb,
  input  logic [TOL_W-1:0] tol,
  output logic             exceeds
);

  localparam int CNT_W = MHZ_W + $clog2(WIN_US);

  // ---------------- link clock domain ----------------
  logic [1:0]       linkRstPipe;
  logic [CNT_W-1:0] linkCnt, linkCntNxt, linkGray;

  always_ff @(posedge linkClk or negedge rstN) begin
    if (!rstN) linkRstPipe <= '0;
    else       linkRstPipe <= {linkRstPipe[0], 1'b1};
  end

  assign linkCntNxt = linkCnt + 1'b1;

  always_ff @(posedge linkClk or negedge rstN) begin
    if (!rstN) begin
      linkCnt  <= '0;
      linkGray <= '0;
    end else if (linkRstPipe[1]) begin
      linkCnt  <= linkCntNxt;
      linkGray <= linkCntNxt ^ (linkCntNxt >> 1);
    end
  end

  // ---------------- reference clock domain ----------------
  logic [CNT_W-1:0] graySync1, graySync2, syncBin, prevSample, delta;
  logic [MHZ_W-1:0] deltaMhz, measMhz, baseMhz, absDiff;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      graySync1 <= '0;
      graySync2 <= '0;
    end else begin
      graySync1 <= linkGray;
      graySync2 <= graySync1;
    end
  end

  always_comb begin
    syncBin[CNT_W-1] = graySync2[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) syncBin[i] = syncBin[i+1] ^ graySync2[i];
  end

  assign delta = syncBin - prevSample;

  generate
    if (WIN_US == 1) begin : g_unitWin
      assign deltaMhz = delta;
    end else begin : g_scaledWin
      logic [CNT_W-1:0] quot;
      assign quot     = delta / CNT_W'(WIN_US);
      assign deltaMhz = quot[MHZ_W-1:0];
    end
  endgenerate

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
      measMhz    <= '0;
      baseMhz    <= '0;
    end else begin
      if (strb.winEnd) begin
        prevSample <= syncBin;
        measMhz    <= deltaMhz;
      end
      if (strb.loadBase) baseMhz <= measMhz;
    end
  end

  assign absDiff = (measMhz >= baseMhz) ? measMhz - baseMhz : baseMhz - measMhz;
  assign exceeds = absDiff > MHZ_W'(tol);

  // R3: the crossing counter moves by at most one code between reference samples
  // R3
  gray_step_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $countones(graySync1 ^ graySync2) <= 1);

endmodule

// File: rtl/lfm_control.sv
module lfm_control
  import lfm_pkg::*;
#(
  parameter int WIN_CYC = 250,
  parameter int TOL_W   = 4,
  parameter int TOL_RST = 4
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regAddr,
  input  logic [TOL_W-1:0] regWrData,
  output logic [TOL_W-1:0] regRdData,
  input  logic             exceeds,
  output lfmStrobe_t       strb,
  output logic [TOL_W-1:0] tol,
  output logic             rawFlag,
  output logic             muteMask
);

  localparam int WCNT_W = $clog2(WIN_CYC);

  logic [WCNT_W-1:0] winCnt;
  logic              winLast, evalStb, changeDet, clrHit;
  lfmPhase_t         phase;

  assign winLast = (winCnt == WCNT_W'(WIN_CYC - 1));

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      evalStb <= 1'b0;
      phase   <= PH_PRIME;
    end else begin
      winCnt  <= winLast ? '0 : winCnt + 1'b1;
      evalStb <= winLast;
      if (evalStb && phase != PH_RUN) phase <= (phase == PH_PRIME) ? PH_BASE : PH_RUN;
    end
  end

  assign changeDet     = evalStb && (phase == PH_RUN) && exceeds;
  assign strb.winEnd   = winLast;
  assign strb.loadBase = evalStb && ((phase == PH_BASE) || changeDet);
  assign clrHit        = regWe && regAddr && regWrData[0];

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      tol      <= TOL_W'(TOL_RST);
      rawFlag  <= 1'b0;
      muteMask <= 1'b0;
    end else begin
      if (regWe && !regAddr) tol <= regWrData;
      if (changeDet)   rawFlag <= 1'b1;
      else if (clrHit) rawFlag <= 1'b0;
      muteMask <= changeDet;
    end
  end

  assign regRdData = regAddr ? {{(TOL_W-1){1'b0}}, rawFlag} : tol;

  // R5
  raw_hold_chk: assert property (@(posedge refClk) disable iff (!rstN)
    rawFlag && !clrHit |=> rawFlag);
  // R6
  det_wins_chk: assert property (@(posedge refClk) disable iff (!rstN)
    changeDet && clrHit |=> rawFlag);
  // R8
  mute_raw_chk: assert property (@(posedge refClk) disable iff (!rstN)
    muteMask |-> rawFlag);
  // R8
  mute_pulse_chk: assert property (@(posedge refClk) disable iff (!rstN)
    muteMask |=> !muteMask);
  // R8
  raw_rise_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(rawFlag) |-> muteMask);

endmodule

// File: rtl/lnk_freq_mon.sv
module lnk_freq_mon #(
  parameter int REF_MHZ = 250,
  parameter int WIN_US  = 1,
  parameter int MHZ_W   = 10,
  parameter int TOL_W   = 4,
  parameter int TOL_RST = 4
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             linkClk,
  input  logic             regWe,
  input  logic             regAddr,
  input  logic [TOL_W-1:0] regWrData,
  output logic [TOL_W-1:0] regRdData,
  output logic             freqChanged,
  output logic             muteMask
);

  localparam int WIN_CYC = REF_MHZ * WIN_US;

  lfm_pkg::lfmStrobe_t strb;
  logic [TOL_W-1:0]    tol;
  logic                exceeds;

  lfm_control #(
    .WIN_CYC(WIN_CYC), .TOL_W(TOL_W), .TOL_RST(TOL_RST)
  ) u_ctrl (
    .refClk(refClk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .exceeds(exceeds), .strb(strb), .tol(tol),
    .rawFlag(freqChanged), .muteMask(muteMask)
  );

  lfm_datapath #(
    .MHZ_W(MHZ_W), .TOL_W(TOL_W), .WIN_US(WIN_US)
  ) u_dp (
    .refClk(refClk), .rstN(rstN), .linkClk(linkClk),
    .strb(strb), .tol(tol), .exceeds(exceeds)
  );

endmodule

// File: tb/sim_lnk_freq_mon.sv
module sim_lnk_freq_mon;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WIN = 250;

  logic       refClk = 1'b0, rstN = 1'b0, linkClk = 1'b0;
  logic       regWe = 1'b0, regAddr = 1'b0;
  logic [3:0] regWrData = '0;
  logic [3:0] regRdData;
  logic       freqChanged, muteMask;

  real linkMhz = 50.0;
  int  vecs = 0, bad = 0, edgeN = 0, muteSeen = 0;
  int  baseF, tolM, expRaw;

  lnk_freq_mon u0 (
    .refClk(refClk), .rstN(rstN), .linkClk(linkClk),
    .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .freqChanged(freqChanged), .muteMask(muteMask)
  );

  always #2 refClk = ~refClk;
  initial forever begin
    #(500.0 / linkMhz);
    linkClk = ~linkClk;
  end

  always @(posedge refClk) begin
    if (!rstN) edgeN <= 0;
    else       edgeN <= edgeN + 1;
  end
  always @(negedge refClk) if (rstN && muteMask) muteSeen = muteSeen + 1;

  function automatic int absI(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int expectDet(int f, int b, int t);
    return (absI(f - b) > t) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(logic a, logic [3:0] d);
    @(negedge refClk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge refClk);
    regWe = 1'b0;
  endtask

  task automatic regRead(logic a, output int v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic waitAlign();
    do @(negedge refClk); while (edgeN % WIN != WIN - 2);
  endtask

  // step link frequency at a window boundary, then check after evaluation
  task automatic stepTo(int f, string req);
    int m0, det, rd;
    waitAlign();
    linkMhz = f;
    m0 = muteSeen;
    repeat (WIN + 4) @(negedge refClk);
    det = expectDet(f, baseF, tolM);
    if (det != 0) begin baseF = f; expRaw = 1; end
    check(req, freqChanged, expRaw);
    regRead(1'b1, rd);
    check({req, " status read"}, rd, expRaw);
    check("R8 mute pulses", muteSeen - m0, det);
  endtask

  task automatic setTol(int t);
    int rd;
    regWrite(1'b0, 4'(t));
    tolM = t;
    regRead(1'b0, rd);
    check("R2 tolerance readback", rd, t);
  endtask

  task automatic clearFlag();
    int rd;
    regWrite(1'b1, 4'b0001);
    expRaw = 0;
    regRead(1'b1, rd);
    check("R5 clear", rd, 0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int rd, f, m0;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge refClk);
    rstN = 1'b1;
    #0.5;
    // R1 reset state
    regRead(1'b0, rd); check("R1 tolerance reset", rd, 4);
    regRead(1'b1, rd); check("R1 flag reset", rd, 0);
    check("R1 mute reset", muteMask, 0);
    tolM = 4; baseF = 50; expRaw = 0;

    // R3: first windows only prime and set baseline
    repeat (3 * WIN + 5) @(negedge refClk);
    check("R3 no flag while priming", freqChanged, 0);
    check("R3 no mute while priming", muteSeen, 0);

    // R2: tolerance write, then status-address write leaves it alone
    setTol(9);
    regWrite(1'b1, 4'b1110);
    regRead(1'b0, rd); check("R2 tolerance after status write", rd, 9);

    // R4: within and beyond tolerance
    stepTo(55, "R4 within tolerance");
    stepTo(62, "R4 beyond tolerance");

    // R5: writing bit0=0 does nothing; bit0=1 clears
    regWrite(1'b1, 4'b0000);
    regRead(1'b1, rd); check("R5 zero write ignored", rd, 1);
    check("R5 flag port held", freqChanged, 1);
    clearFlag();

    // R7: drift accumulates against an unchanged baseline
    setTol(10);
    stepTo(67, "R7 small drift");
    stepTo(75, "R7 accumulated drift");
    clearFlag();

    // R4: zero tolerance flags any difference
    setTol(0);
    stepTo(80, "R4 zero tolerance");
    clearFlag();

    // R6: clear lands in the evaluation cycle of a detection
    waitAlign();
    linkMhz = 100;
    m0 = muteSeen;
    repeat (WIN + 2) @(negedge refClk);
    regWe = 1'b1; regAddr = 1'b1; regWrData = 4'b0001;
    @(negedge refClk);
    regWe = 1'b0;
    check("R6 detection beats clear", freqChanged, 1);
    @(negedge refClk);
    check("R6 mute on collision", muteSeen - m0, 1);
    baseF = 100; expRaw = 1;

    // constrained random steps
    for (int n = 0; n < 14; n++) begin
      setTol($urandom_range(15, 0));
      do f = $urandom_range(150, 20);
      while (absI(absI(f - baseF) - tolM) < 3);
      stepTo(f, "R4 random step");
      if ($urandom_range(1, 0) == 1) clearFlag();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule